// File: doc/BRIEF.md
# ADC Result and Interrupt Logic

This block sits between an abstracted eight-channel converter core and a simple register bus. Each time the core reports a finished conversion, it delivers a channel number, a 12-bit sample and a flag that says whether it is running in burst mode. The block stores the sample twice. One copy goes into a shared "latest result" word, which also records the channel. The other goes into the result word of that channel. Each word has a DONE flag and an OVERRUN flag.

Reading a status word has side effects. The read returns the word and clears its DONE and OVERRUN flags. A write to the control address models a restart of the converter. If the core is idle, the write clears the shared DONE flag. If the core is mid-conversion, the write sets DONE and asks the core to restart. One level interrupt output is driven from an enable word. A select bit in that word routes either the shared DONE flag or the enabled per-channel DONE flags to the output.

Word addresses: 0 is the control address, 1 is the latest-result word, 2 is the interrupt enable word, and 4 to 11 are the result words for channels 0 to 7. Every other address reads zero. Read data is combinational from the current address. A read has its side effects on the clock edge at which `bus_rd` is high.

Top module: `adc_status_regs`

## Requirements
- R1: Read data is zero at the control address, at address 3 and at addresses 12 to 15. In every status word, bits 29:27 read zero.
- R2: A completion strobe sets the latest-result DONE (bit 31) at the next edge. It loads the sample into bits 15:4 and the channel into bits 26:24.
- R3: A read of the latest-result word returns its value before the read. It then clears DONE (bit 31) and OVERRUN (bit 30).
- R4: A control write while `cvt_busy` is low clears the latest-result DONE. While `cvt_busy` is high, the write sets DONE and drives `cvt_restart` high in that same cycle.
- R5: A completion on channel n sets DONE (bit 31) of word 4+n and loads the sample into bits 15:4. A read of that word clears its DONE and OVERRUN and leaves the other channels unchanged. Bits 26:24 of a channel word read zero.
- R6: In burst mode, a completion that overwrites a word whose DONE is still set sets that word's OVERRUN. This applies to both the latest-result word and the channel word. OVERRUN then stays set until the word is read.
- R7: A completion with `cvt_burst` low never sets any OVERRUN flag.
- R8: The interrupt enable word keeps bits 8:0 from a write and reads zero in bits 31:9. Bits 7:0 enable channels 0 to 7, and bit 8 selects the interrupt source.
- R9: With enable bit 8 set, `irq` equals the latest-result DONE flag.
- R10: With enable bit 8 clear, `irq` is the OR over channels of channel DONE AND enable bit. It falls once reads have cleared those flags.
- R11: If a completion and a clearing read of the same word fall in one cycle, DONE stays set. OVERRUN is not set by that overwrite, because the old sample was read.
- R12: After reset, all DONE and OVERRUN flags are 0, the enable word reads 0x100, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cvt_valid | input | 1 | Conversion-complete strobe from the core |
| cvt_chan | input | 3 | Channel of the finished conversion |
| cvt_data | input | 12 | Converted sample |
| cvt_burst | input | 1 | Core is in burst mode |
| cvt_busy | input | 1 | Core has a conversion in progress |
| cvt_restart | output | 1 | Restart request to the core, raised with a control write while busy |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; applies the clear side effects |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: eight channels and a 4-bit word address. This places every channel word, the highest channel and the unmapped addresses 3 and 12 to 15 within reach of a random address.

Three sources of status changes can collide with each other: burst and single completions, clearing reads, and control writes issued while the core is busy or idle. Random traffic, with both settings of the source select bit, makes these collisions happen at random. Directed sequences force the cases that rarely arise by chance: the same-cycle read and completion collision, and an overrun built from two burst completions.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned RES_W     = 12;
  parameter int unsigned RES_LSB   = 4;
  parameter int unsigned CHF_W     = 3;
  parameter int unsigned CHF_LSB   = 24;
  parameter int unsigned OVR_BIT   = 30;
  parameter int unsigned DONE_BIT  = 31;
  parameter int unsigned IEN_W     = 9;
  parameter int unsigned IEN_SEL   = 8;
  parameter int unsigned ADR_CTL   = 0;
  parameter int unsigned ADR_GLB   = 1;
  parameter int unsigned ADR_IEN   = 2;
  parameter int unsigned ADR_CH0   = 4;

  // Assemble a status word from its fields; unnamed bits stay zero.
  function automatic logic [WORD_W-1:0] pack_status(input logic done, input logic ovr,
                                                    input logic [CHF_W-1:0] ch,
                                                    input logic [RES_W-1:0] res);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RES_LSB +: RES_W] = res;
    w[CHF_LSB +: CHF_W] = ch;
    w[OVR_BIT]          = ovr;
    w[DONE_BIT]         = done;
    return w;
  endfunction

  // A result is lost when a burst completion lands on an unread word.
  function automatic logic ovr_next(input logic ovr, input logic done, input logic hit,
                                    input logic burst, input logic rd);
    logic lost;
    lost = hit & burst & done & ~rd;
    return rd ? lost : (ovr | lost);
  endfunction

  // Setting wins over clearing.
  function automatic logic done_next(input logic done, input logic set, input logic clr);
    return set | (done & ~clr);
  endfunction
endpackage

// File: rtl/adc_result_slot.sv
module adc_result_slot
  import adc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             force_set,
  input  logic             clr,
  input  logic             rd,
  input  logic             burst,
  input  logic [RES_W-1:0] res_in,
  output logic             done,
  output logic             ovr,
  output logic [RES_W-1:0] res
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      ovr  <= 1'b0;
      res  <= '0;
    end else begin
      done <= done_next(done, load | force_set, clr);
      ovr  <= ovr_next(ovr, done, load, burst, rd);
      if (load) res <= res_in;
    end
  end
endmodule

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ctl_wr,
  output logic              ien_wr,
  output logic              g_rd,
  output logic [NUM_CH-1:0] ch_rd
);
  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CTL));
  assign ien_wr = bus_wr && (bus_addr == ADDR_W'(ADR_IEN));
  assign g_rd   = bus_rd && (bus_addr == ADDR_W'(ADR_GLB));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chrd
    assign ch_rd[i] = bus_rd && (bus_addr == ADDR_W'(ADR_CH0 + i));
  end
endmodule

// File: rtl/adc_irq_route.sv
module adc_irq_route #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              src_glb,
  input  logic              g_done,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic [NUM_CH-1:0] ch_en,
  output logic              irq
);
  always_comb begin
    if (src_glb) irq = g_done;
    else         irq = |(ch_done & ch_en);
  end
endmodule

// File: rtl/adc_status_regs.sv
module adc_status_regs
  import adc_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cvt_valid,
  input  logic [$clog2(NUM_CH)-1:0]  cvt_chan,
  input  logic [RES_W-1:0]           cvt_data,
  input  logic                       cvt_burst,
  input  logic                       cvt_busy,
  output logic                       cvt_restart,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [WORD_W-1:0]          bus_wdata,
  output logic [WORD_W-1:0]          bus_rdata,
  output logic                       irq
);
  localparam int unsigned CH_W = $clog2(NUM_CH);
  localparam logic [IEN_W-1:0] IEN_RST = IEN_W'(1) << IEN_SEL;

  // Named internal events, visible to the checker.
  logic              ctl_wr, ien_wr, g_rd;
  logic [NUM_CH-1:0] ch_rd, ch_hit, ch_done, ch_ovr;
  logic              g_done, g_ovr, ien_sel;
  logic [RES_W-1:0]  g_res;
  logic [RES_W-1:0]  ch_res [NUM_CH];
  logic [CH_W-1:0]   g_ch;
  logic [IEN_W-1:0]  ien_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[WORD_W-1:IEN_W];

  adc_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .ctl_wr(ctl_wr), .ien_wr(ien_wr), .g_rd(g_rd), .ch_rd(ch_rd)
  );

  assign cvt_restart = ctl_wr & cvt_busy;

  adc_result_slot u_glb (
    .clk(clk), .rst_n(rst_n), .load(cvt_valid), .force_set(cvt_restart),
    .clr(g_rd | ctl_wr), .rd(g_rd), .burst(cvt_burst), .res_in(cvt_data),
    .done(g_done), .ovr(g_ovr), .res(g_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         g_ch <= '0;
    else if (cvt_valid) g_ch <= cvt_chan;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign ch_hit[i] = cvt_valid && (cvt_chan == CH_W'(i));
    adc_result_slot u_slot (
      .clk(clk), .rst_n(rst_n), .load(ch_hit[i]), .force_set(1'b0),
      .clr(ch_rd[i]), .rd(ch_rd[i]), .burst(cvt_burst), .res_in(cvt_data),
      .done(ch_done[i]), .ovr(ch_ovr[i]), .res(ch_res[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= IEN_RST;
    else if (ien_wr) ien_q <= bus_wdata[IEN_W-1:0];
  end
  assign ien_sel = ien_q[IEN_SEL];

  adc_irq_route #(.NUM_CH(NUM_CH)) u_irq (
    .src_glb(ien_sel), .g_done(g_done), .ch_done(ch_done),
    .ch_en(ien_q[NUM_CH-1:0]), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_GLB))
      bus_rdata = pack_status(g_done, g_ovr, CHF_W'(g_ch), g_res);
    else if (bus_addr == ADDR_W'(ADR_IEN))
      bus_rdata[IEN_W-1:0] = ien_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(ADR_CH0 + i))
        bus_rdata = pack_status(ch_done[i], ch_ovr[i], '0, ch_res[i]);
    end
  end
endmodule

// File: rtl/adc_status_regs_chk.sv
module adc_status_regs_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cvt_valid,
  input logic              cvt_burst,
  input logic              cvt_busy,
  input logic              irq,
  input logic              g_done,
  input logic              g_ovr,
  input logic              g_rd,
  input logic              ctl_wr,
  input logic              ien_sel,
  input logic [NUM_CH-1:0] ch_done
);
  // R2
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_valid |=> g_done);

  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_rd && !cvt_valid && !(ctl_wr && cvt_busy)) |=> (!g_done && !g_ovr));

  // R4
  busy_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cvt_busy) |=> g_done);

  // R4
  idle_ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !cvt_busy && !cvt_valid) |=> !g_done);

  // R7
  no_burst_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_valid && !cvt_burst && !g_rd) |=> $stable(g_ovr));

  // R9
  glb_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_sel |-> (irq == g_done));

  // R10
  ch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_sel && ch_done == '0) |-> !irq);
endmodule

bind adc_status_regs adc_status_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cvt_valid(cvt_valid), .cvt_burst(cvt_burst),
  .cvt_busy(cvt_busy), .irq(irq), .g_done(g_done), .g_ovr(g_ovr), .g_rd(g_rd),
  .ctl_wr(ctl_wr), .ien_sel(ien_sel), .ch_done(ch_done)
);

// File: tb/adc_status_regs_test.sv
module adc_status_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cvt_valid = 0, cvt_burst = 0, cvt_busy = 0;
  logic [2:0]  cvt_chan = '0;
  logic [11:0] cvt_data = '0;
  logic        cvt_restart, irq;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_total = 0, n_fail = 0;

  // Reference state
  bit        m_gdone, m_govr;
  bit [2:0]  m_gch;
  bit [11:0] m_gres;
  bit        m_cdone [8];
  bit        m_covr [8];
  bit [11:0] m_cres [8];
  bit [8:0]  m_en;

  always #4 clk = ~clk;

  adc_status_regs uut (
    .clk(clk), .rst_n(rst_n), .cvt_valid(cvt_valid), .cvt_chan(cvt_chan),
    .cvt_data(cvt_data), .cvt_burst(cvt_burst), .cvt_busy(cvt_busy),
    .cvt_restart(cvt_restart), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic bit [31:0] word_of(bit d, bit o, bit [2:0] c, bit [11:0] r);
    return {d, o, 3'b000, c, 8'h00, r, 4'h0};
  endfunction

  function automatic bit [31:0] exp_read(bit [3:0] a);
    if (a == 4'd1) return word_of(m_gdone, m_govr, m_gch, m_gres);
    if (a == 4'd2) return {23'd0, m_en};
    if (a >= 4'd4 && a <= 4'd11) return word_of(m_cdone[a-4], m_covr[a-4], 3'd0, m_cres[a-4]);
    return 32'd0;
  endfunction

  function automatic bit exp_irq();
    bit any = 0;
    for (int i = 0; i < 8; i++) any |= m_cdone[i] & m_en[i];
    return m_en[8] ? m_gdone : any;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string addr_tag(bit [3:0] a);
    if (a == 4'd1) return "R3";
    if (a == 4'd2) return "R8";
    if (a >= 4'd4 && a <= 4'd11) return "R5";
    return "R1";
  endfunction

  // Reference update at a clock edge from the inputs held across it.
  task automatic model_step();
    bit grd, ctl, crd, hit;
    grd = bus_rd && bus_addr == 4'd1;
    ctl = bus_wr && bus_addr == 4'd0;
    for (int i = 0; i < 8; i++) begin
      crd = bus_rd && bus_addr == 4'(4 + i);
      hit = cvt_valid && cvt_chan == 3'(i);
      if (crd) m_covr[i] = hit && cvt_burst && m_cdone[i] && 1'b0;
      else if (hit && cvt_burst && m_cdone[i]) m_covr[i] = 1;
      if (hit) begin m_cdone[i] = 1; m_cres[i] = cvt_data; end
      else if (crd) m_cdone[i] = 0;
    end
    if (grd) m_govr = 0;
    else if (cvt_valid && cvt_burst && m_gdone) m_govr = 1;
    if (cvt_valid || (ctl && cvt_busy)) m_gdone = 1;
    else if (grd || ctl) m_gdone = 0;
    if (cvt_valid) begin m_gch = cvt_chan; m_gres = cvt_data; end
    if (bus_wr && bus_addr == 4'd2) m_en = bus_wdata[8:0];
  endtask

  // One cycle, starting at a falling edge.
  task automatic cyc(bit v, bit [2:0] ch, bit [11:0] d, bit bu, bit busy,
                     bit wr, bit rd, bit [3:0] a, bit [31:0] wd, string tag);
    cvt_valid = v; cvt_chan = ch; cvt_data = d; cvt_burst = bu; cvt_busy = busy;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    #1;
    if (rd) check(tag == "" ? addr_tag(a) : tag, bus_rdata, exp_read(a));
    check(m_en[8] ? "R9" : "R10", {31'd0, irq}, {31'd0, exp_irq()});
    check("R4", {31'd0, cvt_restart}, {31'd0, bit'(wr && a == 4'd0 && busy)});
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, ""); endtask
  task automatic rd(bit [3:0] a, string tag); cyc(0, 0, 0, 0, 0, 0, 1, a, 0, tag); endtask
  task automatic conv(bit [2:0] ch, bit [11:0] d, bit bu); cyc(1, ch, d, bu, 0, 0, 0, 0, 0, ""); endtask
  task automatic wr(bit [3:0] a, bit [31:0] wd); cyc(0, 0, 0, 0, 0, 1, 0, a, wd, ""); endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    m_en = 9'h100;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(4'd2, "R12"); rd(4'd1, "R12"); rd(4'd4, "R12"); rd(4'd11, "R12");
    // R2 completion loads fields, R3 read clears
    conv(3'd5, 12'hABC, 0);
    rd(4'd1, "R2"); rd(4'd1, "R3"); rd(4'd9, "R5"); rd(4'd9, "R5");
    // R7 no overrun without burst
    conv(3'd2, 12'h111, 0); conv(3'd2, 12'h222, 0);
    rd(4'd6, "R7"); rd(4'd1, "R7");
    // R6 burst overrun
    conv(3'd3, 12'h333, 1); conv(3'd3, 12'h444, 1);
    rd(4'd7, "R6"); rd(4'd1, "R6"); rd(4'd7, "R6"); rd(4'd1, "R3");
    // R11 completion collides with clearing read
    conv(3'd1, 12'h555, 1);
    cyc(1, 3'd1, 12'h666, 1, 0, 0, 1, 4'd5, 0, "R11");
    cyc(1, 3'd0, 12'h777, 1, 0, 0, 1, 4'd1, 0, "R11");
    rd(4'd5, "R11"); rd(4'd1, "R11");
    // R4 control write while busy and while idle
    cyc(0, 0, 0, 0, 1, 1, 0, 4'd0, 0, "");
    rd(4'd1, "R4");
    conv(3'd4, 12'h888, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 4'd0, 0, "");
    rd(4'd1, "R4");
    // R10 per-channel routing, then R9 global routing
    for (int i = 4; i < 12; i++) rd(4'(i), "R5");
    wr(4'd2, 32'h0000_0004);
    conv(3'd1, 12'h010, 0); idle();
    conv(3'd2, 12'h020, 0); idle();
    rd(4'd6, "R10"); idle();
    wr(4'd2, 32'h0000_0100);
    conv(3'd6, 12'h060, 0); idle(); rd(4'd1, "R9"); idle();
    // R8 reserved enable bits, R1 unmapped reads
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, "R8");
    rd(4'd0, "R1"); rd(4'd3, "R1"); rd(4'd12, "R1"); rd(4'd15, "R1");
    // Random traffic
    for (int k = 0; k < 6000; k++) begin
      bit v, bu, busy, w, r;
      bit [3:0] a;
      bit [31:0] wd;
      v = ($urandom % 3) == 0;
      bu = $urandom % 2;
      busy = $urandom % 2;
      r = ($urandom % 2) == 0;
      w = ($urandom % 10) == 0;
      a = 4'($urandom % 16);
      if (w && ($urandom % 2)) a = 4'(($urandom % 2) * 2);
      wd = $urandom;
      cyc(v, 3'($urandom % 8), 12'($urandom), bu, busy, w, r, a, wd, "");
    end
    finish_run();
  end
endmodule